// File: doc/BRIEF.md
# Sleep and Initialization Mode Handshake Controller

This block sits beside the bit-level engine of a bus protocol peripheral and manages its operating modes. Software raises request bits for low-power sleep and for initialization. The controller answers each request with an acknowledge once the request may be honoured. Sleep is granted only after the bus has gone quiet. Initialization is granted on the next clock.

While initialization is acknowledged, the controller raises a permission signal for writes to the configuration registers. To reconfigure a running module, software follows a fixed order: request sleep and wait for its acknowledge, request initialization and wait for its acknowledge, write the configuration, then drop the initialization request.

During acknowledged sleep, bus activity can set a wake-up flag when wake-up is enabled. With the interrupt enable also set, the flag drives the wake-up interrupt. The flag also withdraws the sleep acknowledge. Software clears the flag with a one-cycle clear strobe. The clear loses if the setting condition is present in the same cycle. While the module enable is low, the controller holds its reset state.

Top module: `mode_hs_ctrl`

## Requirements
- R1: After reset, and on every clock where `mod_en` is 0, the controller returns to its idle state: `init_ack`=1, `slp_ack`=0, wake flag cleared, `wake_irq`=0. All other inputs are ignored while `mod_en` is 0.
- R2: While `mod_en` is 1, `init_ack` equals the value `init_req` had at the previous clock edge. It rises one clock after the request is set and falls one clock after the request is cleared.
- R3: `cfg_wr_ok` is 1 only when `mod_en`, `init_req` and `init_ack` are all 1.
- R4: `slp_ack` rises one clock after an edge at which `slp_req`=1, `bus_idle`=1 and no enabled wake flag is pending. It stays 0 while the bus is busy.
- R5: Clearing `slp_req` drives `slp_ack` to 0 at the next clock edge.
- R6: The wake flag is set at an edge where `slp_req`, `slp_ack`, `wake_en` and `bus_act` are all 1. `wake_irq` is 1 only when the flag, `wake_en` and `wake_ie` are all 1.
- R7: `wake_clr`=1 clears the wake flag at the next edge, unless the set condition of R6 holds at that same edge; in that case the flag stays set.
- R8: While the wake flag is set and `wake_en`=1, `slp_ack` is 0 after the next edge. It cannot be regained until the flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mod_en | input | 1 | Module enable |
| slp_req | input | 1 | Sleep request from software |
| init_req | input | 1 | Initialization request from software |
| bus_idle | input | 1 | Bus is idle, from the protocol engine |
| bus_act | input | 1 | Bus activity detected |
| wake_en | input | 1 | Wake-up function enable |
| wake_ie | input | 1 | Wake-up interrupt enable |
| wake_clr | input | 1 | Clear strobe for the wake flag |
| slp_ack | output | 1 | Sleep acknowledge |
| init_ack | output | 1 | Initialization acknowledge |
| cfg_wr_ok | output | 1 | Configuration writes permitted |
| wake_irq | output | 1 | Wake-up interrupt |

## Verification
Every piece of state in this block reaches a port within one clock, so a wrong state shows up quickly. A bad sleep state shows as an acknowledge that rises while the bus is busy, or that survives a dropped request, on the very next edge. A wrong wake flag shows directly on `wake_irq` when the enables are set. It also shows one edge later as a withdrawn or stuck `slp_ack`. A wrong initialization state appears both on `init_ack` and on `cfg_wr_ok` one clock after the request changes.

// File: rtl/mode_hs_ctrl.sv
module mode_hs_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic mod_en,
  input  logic slp_req,
  input  logic init_req,
  input  logic bus_idle,
  input  logic bus_act,
  input  logic wake_en,
  input  logic wake_ie,
  input  logic wake_clr,
  output logic slp_ack,
  output logic init_ack,
  output logic cfg_wr_ok,
  output logic wake_irq
);

  logic wake_flag;
  logic wake_set;
  logic wake_hold;

  assign wake_set  = slp_req & slp_ack & wake_en & bus_act;
  assign wake_hold = wake_flag & wake_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_ack  <= 1'b1;
      slp_ack   <= 1'b0;
      wake_flag <= 1'b0;
    end else if (!mod_en) begin
      init_ack  <= 1'b1;
      slp_ack   <= 1'b0;
      wake_flag <= 1'b0;
    end else begin
      init_ack <= init_req;

      if (!slp_req || wake_hold)
        slp_ack <= 1'b0;
      else if (bus_idle)
        slp_ack <= 1'b1;

      if (wake_set)
        wake_flag <= 1'b1;
      else if (wake_clr)
        wake_flag <= 1'b0;
    end
  end

  assign cfg_wr_ok = mod_en & init_req & init_ack;
  assign wake_irq  = wake_flag & wake_en & wake_ie;

endmodule

// File: rtl/mode_hs_ctrl_chk.sv
module mode_hs_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic mod_en,
  input logic slp_req,
  input logic init_req,
  input logic bus_idle,
  input logic wake_en,
  input logic wake_ie,
  input logic slp_ack,
  input logic init_ack,
  input logic cfg_wr_ok,
  input logic wake_irq
);

  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> (init_ack && !slp_ack && !wake_irq)); // R1

  AST_INIT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    mod_en |=> (init_ack == $past(init_req))); // R2

  AST_CFG_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_ok && $past(mod_en)) |-> $past(init_req)); // R3

  AST_SLP_WAITS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && !slp_ack && !bus_idle) |=> !slp_ack); // R4

  AST_SLP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && !slp_req) |=> !slp_ack); // R5

  AST_IRQ_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> (wake_en && wake_ie)); // R6

  AST_WAKE_KILLS_SLP: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && wake_irq) |=> !slp_ack); // R8

endmodule

bind mode_hs_ctrl mode_hs_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .slp_req(slp_req),
  .init_req(init_req), .bus_idle(bus_idle), .wake_en(wake_en),
  .wake_ie(wake_ie), .slp_ack(slp_ack), .init_ack(init_ack),
  .cfg_wr_ok(cfg_wr_ok), .wake_irq(wake_irq)
);

// File: tb/mode_hs_ctrl_tb_top.sv
module mode_hs_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mod_en = 0, slp_req = 0, init_req = 0, bus_idle = 0, bus_act = 0;
  logic wake_en = 0, wake_ie = 0, wake_clr = 0;
  logic slp_ack, init_ack, cfg_wr_ok, wake_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [3:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mode_hs_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .slp_req(slp_req),
    .init_req(init_req), .bus_idle(bus_idle), .bus_act(bus_act),
    .wake_en(wake_en), .wake_ie(wake_ie), .wake_clr(wake_clr),
    .slp_ack(slp_ack), .init_ack(init_ack), .cfg_wr_ok(cfg_wr_ok),
    .wake_irq(wake_irq)
  );

  function automatic logic [3:0] outs();
    return {slp_ack, init_ack, cfg_wr_ok, wake_irq};
  endfunction

  task automatic compare(input logic [3:0] exp, input string tag);
    checks++;
    if (outs() !== exp) begin
      errors++;
      $display("FAIL %s: {slp,init,cfg,irq} actual %b expected %b", tag, outs(), exp);
    end
  endtask

  task automatic drive(input logic en, input logic sr, input logic ir, input logic idle,
                       input logic act, input logic we, input logic wie, input logic clr,
                       input logic [3:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    mod_en = en; slp_req = sr; init_req = ir; bus_idle = idle;
    bus_act = act; wake_en = we; wake_ie = wie; wake_clr = clr;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        compare(it.exp, it.tag);
      end
    end
  end

  initial begin : watchdog
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (2) @(negedge clk);
    compare(4'b0100, "R1 reset state");
    rst_n = 1'b1;
    //     en sr ir id ac we ie cl  {slp,init,cfg,irq}
    drive(0, 1, 0, 1, 0, 0, 0, 0, 4'b0100, "R1 requests ignored while disabled");
    drive(1, 0, 1, 1, 0, 0, 0, 0, 4'b0110, "R3 init acked opens config writes");
    drive(1, 0, 0, 1, 0, 0, 0, 0, 4'b0000, "R2 init ack drops one clock after request");
    drive(1, 1, 0, 0, 0, 0, 0, 0, 4'b0000, "R4 sleep waits for idle bus");
    drive(1, 1, 0, 0, 0, 0, 0, 0, 4'b0000, "R4 sleep still waiting");
    drive(1, 1, 0, 1, 0, 0, 0, 0, 4'b1000, "R4 sleep acked once idle");
    drive(1, 1, 1, 1, 0, 0, 0, 0, 4'b1110, "R2 init acked inside sleep");
    drive(1, 1, 0, 1, 0, 0, 0, 0, 4'b1000, "R3 config closed after init cleared");
    drive(1, 1, 0, 0, 1, 1, 1, 0, 4'b1001, "R6 activity in sleep raises irq");
    drive(1, 1, 0, 1, 0, 1, 1, 0, 4'b0001, "R8 wake flag withdraws sleep ack");
    drive(1, 1, 0, 1, 0, 1, 1, 1, 4'b0000, "R7 clear strobe drops flag");
    drive(1, 1, 0, 1, 0, 1, 1, 0, 4'b1000, "R8 sleep regained after flag cleared");
    drive(1, 1, 0, 0, 1, 0, 1, 0, 4'b1000, "R6 no flag with wake disabled");
    drive(1, 1, 0, 0, 1, 1, 0, 0, 4'b1000, "R6 flag set but interrupt masked");
    drive(1, 1, 0, 0, 1, 1, 1, 1, 4'b0001, "R7 set beats clear in same cycle");
    drive(1, 1, 0, 0, 1, 1, 1, 1, 4'b0000, "R7 clear wins once sleep gone");
    drive(1, 0, 0, 1, 0, 1, 1, 0, 4'b0000, "R5 no sleep ack without request");
    drive(1, 1, 0, 1, 0, 0, 0, 0, 4'b1000, "R4 sleep acked on idle bus");
    drive(1, 0, 0, 1, 0, 0, 0, 0, 4'b0000, "R5 sleep ack drops after request cleared");
    drive(1, 1, 0, 1, 0, 0, 0, 0, 4'b1000, "R4 sleep acked again");
    drive(0, 1, 1, 1, 0, 0, 0, 0, 4'b0100, "R1 disable returns to idle state");
    drive(1, 1, 1, 1, 0, 0, 0, 0, 4'b1110, "R2 enabled again with both requests");
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule